// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block keeps a request register and an in-service register for a group of interrupt levels (eight by default). It decides which pending, unmasked level may interrupt the processor. Request lines are captured either on their rising edge or by following their level. Priority is a circular order defined by whichever level is currently the lowest. A pending level raises the interrupt output only when it outranks every level already in service. The block drives a registered interrupt flag and the index of the winning level toward the processor.

Acknowledge logic outside the block pulses a mark strobe when the processor accepts the interrupt. That strobe moves the level shown on the index output from pending to in service. Software commands end service for the highest-ranked level or for a named level. The rotating variants also move the lowest-priority position, and a separate command reassigns that position without touching service state. Bus decoding and acknowledge cycle timing are handled elsewhere.

Top module: `irq_prio_resolver`

## Requirements
- R1: Synchronous active-high reset clears the pending and in-service registers, drives `irq_o` to 0 and `vec_o` to 0, and sets level N-1 as lowest priority, so level 0 ranks highest.
- R2: With `level_mode_i` = 0, a rising edge on `req_i[k]` sets pending bit k, and the bit stays set after the line falls, until it is acknowledged.
- R3: With `level_mode_i` = 1, pending bit k equals `req_i[k]` as sampled on each clock edge.
- R4: A request whose `mask_i` bit is 1 stays pending but never raises `irq_o`. It wins normally once the mask bit returns to 0.
- R5: `irq_o` is raised only when the highest-ranked pending unmasked level ranks strictly above every in-service level. `vec_o` then names that level. Equal or lower levels are held off.
- R6: `ack_i` high on an edge clears pending bit `vec_o` and sets in-service bit `vec_o`. No in-service bit is ever set without `ack_i`.
- R7: Command code 1 (end service, implied level) clears the highest-ranked set in-service bit. It does nothing when none is set.
- R8: Command code 2 (end service, named level) clears in-service bit `cmd_level_i`.
- R9: Code 3 acts as code 1 and code 4 acts as code 2. Each then makes the cleared level the lowest priority. Code 3 with no in-service bit changes nothing.
- R10: Code 5 makes `cmd_level_i` the lowest priority and leaves the in-service register unchanged.
- R11: `irq_o` and `vec_o` are registers. They reflect the pending, in-service and priority state held before a clock edge and the mask sampled on that edge. When nothing is pending and unmasked, `vec_o` is 0.
- R12: A command acts only when `cmd_valid_i` is 1. Codes 0, 6 and 7 have no effect.
- R13: When `ack_i` and an end-service command fall on the same edge, clearing is computed from the old in-service state first, and the mark is applied after it, so the marked bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Raw request lines |
| mask_i | input | N | Per-level mask, 1 = masked |
| level_mode_i | input | 1 | 0 = rising-edge capture, 1 = level-following |
| ack_i | input | 1 | Mark level `vec_o` as in service |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R7 to R12) |
| cmd_level_i | input | $clog2(N) | Level operand for named-level commands |
| irq_o | output | 1 | Interrupt request toward the processor |
| vec_o | output | $clog2(N) | Index of the winning level |

## Verification
The mark strobe and an end-service command can meet on one edge. One form ends service on the very level being marked. Another ends service for an older level while a newer one is marked. The bench drives both on the same cycle in a directed case. It judges the result at the ports: a lower request raised afterwards must stay blocked only if the marked bit survived. A behavioural model in the bench also replays thousands of random cycles in which marks, commands, mask changes and mode flips overlap. It compares both outputs on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_END_TOP = 3'd1,
    CMD_END_LVL = 3'd2,
    CMD_ROT_TOP = 3'd3,
    CMD_ROT_LVL = 3'd4,
    CMD_SET_LOW = 3'd5,
    CMD_RSV6    = 3'd6,
    CMD_RSV7    = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Circular priority pick: rotate so the highest-ranked level sits at bit 0,
// fixed encode, rotate the index back. rank_o is the index in rotated space.
module irq_prio_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] lowest_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o,
  output logic [W-1:0] rank_o
);
  logic [W-1:0]   shift;
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [W-1:0]   enc;

  always_comb begin
    shift = lowest_i + W'(1);
    dbl   = {vec_i, vec_i} >> shift;
    rot   = dbl[N-1:0];
    enc   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) enc = W'(i);
    end
  end

  assign valid_o = |vec_i;
  assign rank_o  = enc;
  assign idx_o   = enc + shift;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic         level_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_d;

  always_comb begin
    if (level_mode_i) pend_d = req_i & ~clr_i;
    else              pend_d = (pend_o & ~clr_i) | (req_i & ~req_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/irq_service_ctl.sv
module irq_service_ctl
  import irq_prio_pkg::*;
#(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mark_i,
  input  logic [W-1:0] mark_idx_i,
  input  logic         cmd_valid_i,
  input  cmd_op_e      cmd_op_i,
  input  logic [W-1:0] cmd_level_i,
  input  logic         top_valid_i,
  input  logic [W-1:0] top_idx_i,
  output logic [N-1:0] insvc_o,
  output logic [W-1:0] lowest_o
);
  logic [N-1:0] clr;
  logic [N-1:0] set;
  logic [W-1:0] lowest_d;

  always_comb begin
    clr      = '0;
    lowest_d = lowest_o;
    if (cmd_valid_i) begin
      case (cmd_op_i)
        CMD_END_TOP: if (top_valid_i) clr[top_idx_i] = 1'b1;
        CMD_END_LVL: clr[cmd_level_i] = 1'b1;
        CMD_ROT_TOP: if (top_valid_i) begin
          clr[top_idx_i] = 1'b1;
          lowest_d       = top_idx_i;
        end
        CMD_ROT_LVL: begin
          clr[cmd_level_i] = 1'b1;
          lowest_d         = cmd_level_i;
        end
        CMD_SET_LOW: lowest_d = cmd_level_i;
        default: ;
      endcase
    end
    set = mark_i ? (N'(1) << mark_idx_i) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc_o  <= '0;
      lowest_o <= W'(N - 1);
    end else begin
      insvc_o  <= (insvc_o & ~clr) | set;
      lowest_o <= lowest_d;
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic         level_mode_i,
  input  logic         ack_i,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_op_i,
  input  logic [W-1:0] cmd_level_i,
  output logic         irq_o,
  output logic [W-1:0] vec_o
);
  logic [N-1:0] irr;
  logic [N-1:0] isr;
  logic [N-1:0] cand;
  logic [N-1:0] ack_clr;
  logic [W-1:0] lowest;
  logic         req_v, isr_v, grant;
  logic [W-1:0] req_idx, req_rank, isr_idx, isr_rank;

  assign cand    = irr & ~mask_i;
  assign ack_clr = ack_i ? (N'(1) << vec_o) : '0;

  irq_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .req_i(req_i), .level_mode_i(level_mode_i),
    .clr_i(ack_clr), .pend_o(irr)
  );

  irq_prio_pick #(.N(N)) u_pick_req (
    .vec_i(cand), .lowest_i(lowest), .valid_o(req_v), .idx_o(req_idx),
    .rank_o(req_rank)
  );

  irq_prio_pick #(.N(N)) u_pick_isr (
    .vec_i(isr), .lowest_i(lowest), .valid_o(isr_v), .idx_o(isr_idx),
    .rank_o(isr_rank)
  );

  irq_service_ctl #(.N(N)) u_svc (
    .clk(clk), .rst(rst), .mark_i(ack_i), .mark_idx_i(vec_o),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_e'(cmd_op_i)),
    .cmd_level_i(cmd_level_i), .top_valid_i(isr_v), .top_idx_i(isr_idx),
    .insvc_o(isr), .lowest_o(lowest)
  );

  assign grant = req_v && (!isr_v || (req_rank < isr_rank));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= grant;
      vec_o <= req_v ? req_idx : '0;
    end
  end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] mask_i,
  input logic         ack_i,
  input logic         cmd_valid_i,
  input logic [2:0]   cmd_op_i,
  input logic         irq_o,
  input logic [W-1:0] vec_o,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr
);
  logic [N-1:0] mask_q;
  logic [N-1:0] irr_q;

  always_ff @(posedge clk) begin
    mask_q <= mask_i;
    irr_q  <= irr;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (irr == '0 && isr == '0 && !irq_o));

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !mask_q[vec_o]);

  assert_grant_pending_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irr_q[vec_o]);

  assert_mark_only_by_ack_R6: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> ((isr & ~$past(isr)) == '0));

  assert_end_top_one_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 3'd1 && !ack_i && isr != '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1));

  assert_set_low_keeps_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 3'd5 && !ack_i) |=> (isr == $past(isr)));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .mask_i(mask_i), .ack_i(ack_i),
  .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .irq_o(irq_o),
  .vec_o(vec_o), .irr(irr), .isr(isr)
);

// File: tb/irq_prio_resolver_tb.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] mask = '0;
  logic         lvl_mode = 1'b0;
  logic         ack = 1'b0;
  logic         cmd_v = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [W-1:0] cmd_lvl = '0;
  logic         irq_o;
  logic [W-1:0] vec_o;

  always #2 clk = ~clk;

  irq_prio_resolver #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .level_mode_i(lvl_mode),
    .ack_i(ack), .cmd_valid_i(cmd_v), .cmd_op_i(cmd_op), .cmd_level_i(cmd_lvl),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  int    tests = 0;
  int    fails = 0;
  bit    done  = 0;
  bit    cmp_on = 0;
  string tag = "R1";

  // behavioural reference
  bit [N-1:0] m_irr, m_isr, m_reqq;
  int         m_low;
  bit         m_irq;
  int         m_vec;

  function automatic int top_of(bit [N-1:0] v, int low);
    for (int k = 1; k <= N; k++) begin
      int l = (low + k) % N;
      if (v[l]) return l;
    end
    return -1;
  endfunction

  function automatic int rank_of(int l, int low);
    return (l - low - 1 + 2 * N) % N;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_irr = '0; m_isr = '0; m_reqq = '0; m_low = N - 1; m_irq = 0; m_vec = 0;
    end else begin
      bit [N-1:0] clr_p, clr_s, set_s;
      int w, t, n_low;
      w = top_of(m_irr & ~mask, m_low);
      t = top_of(m_isr, m_low);
      clr_p = ack ? (N'(1) << m_vec) : '0;
      set_s = clr_p;
      clr_s = '0;
      n_low = m_low;
      if (cmd_v) begin
        case (cmd_op)
          3'd1: if (t >= 0) clr_s[t] = 1;
          3'd2: clr_s[cmd_lvl] = 1;
          3'd3: if (t >= 0) begin clr_s[t] = 1; n_low = t; end
          3'd4: begin clr_s[cmd_lvl] = 1; n_low = cmd_lvl; end
          3'd5: n_low = cmd_lvl;
          default: ;
        endcase
      end
      m_irq = (w >= 0) && (t < 0 || rank_of(w, m_low) < rank_of(t, m_low));
      m_vec = (w >= 0) ? w : 0;
      if (lvl_mode) m_irr = req & ~clr_p;
      else          m_irr = (m_irr & ~clr_p) | (req & ~m_reqq);
      m_reqq = req;
      m_isr  = (m_isr & ~clr_s) | set_s;
      m_low  = n_low;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      tests++;
      if (irq_o !== m_irq || vec_o !== W'(m_vec)) begin
        fails++;
        $display("FAIL %s model: irq=%0d vec=%0d expected irq=%0d vec=%0d",
                 tag, irq_o, vec_o, m_irq, m_vec);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(bit e_irq, int e_vec, string r);
    tests++;
    if (irq_o !== e_irq || (e_irq && vec_o !== W'(e_vec))) begin
      fails++;
      $display("FAIL %s: irq=%0d vec=%0d expected irq=%0d vec=%0d",
               r, irq_o, vec_o, e_irq, e_vec);
    end
  endtask

  task automatic pulse_req(int l);
    req[l] = 1'b1; tick(1); req[l] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic do_cmd(int op, int l);
    cmd_v = 1'b1; cmd_op = 3'(op); cmd_lvl = W'(l); tick(1); cmd_v = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; mask = '0; ack = 0; cmd_v = 0;
    tick(3); rst = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    cmp_on = 1;
    tag = "R1";
    expect_out(0, 0, "R1 reset outputs");
    tests++;
    if (vec_o !== '0) begin fails++; $display("FAIL R1: vec=%0d expected 0", vec_o); end

    // R4: masked request is held, then wins once unmasked (R11 one-cycle lag)
    tag = "R4";
    mask = 8'h04; pulse_req(2); tick(1);
    expect_out(0, 0, "R4 masked request silent");
    mask = 8'h00; tick(1);
    expect_out(1, 2, "R4 unmask releases latched request (R11)");
    do_ack(); do_cmd(1, 0); tick(1);

    // R2: edge capture holds after line falls
    tag = "R2";
    pulse_req(3); tick(1);
    expect_out(1, 3, "R2 edge latched");
    tick(2);
    expect_out(1, 3, "R2 held after line low");

    // R6 / R5: mark in service, lower blocked, higher passes
    tag = "R6";
    do_ack(); tick(1);
    expect_out(0, 0, "R6 acknowledged level no longer pending");
    tag = "R5";
    pulse_req(5); tick(1);
    expect_out(0, 0, "R5 lower level blocked by in-service");
    pulse_req(1); tick(1);
    expect_out(1, 1, "R5 higher level preempts");

    // R7: end service of top level releases lower pending one
    tag = "R7";
    do_ack(); tick(1);
    expect_out(0, 0, "R7 all pending blocked");
    do_cmd(1, 0); tick(1);
    expect_out(0, 0, "R7 level 3 still in service blocks 5");
    do_cmd(1, 0); tick(1);
    expect_out(1, 5, "R7 second end-service releases 5");

    // R8: named end of service
    tag = "R8";
    do_ack(); pulse_req(6); tick(1);
    expect_out(0, 0, "R8 level 6 blocked by 5");
    do_cmd(2, 5); tick(1);
    expect_out(1, 6, "R8 named clear of 5");

    // R9 / R10: rotation and lowest-priority reassignment
    tag = "R9";
    do_ack(); do_cmd(4, 6);
    req[7] = 1'b1; req[0] = 1'b1; tick(1); req[7] = 1'b0; req[0] = 1'b0; tick(1);
    expect_out(1, 7, "R9 level 7 ranks first after rotate to 6");
    tag = "R10";
    do_cmd(5, 7); tick(1);
    expect_out(1, 0, "R10 set-lowest 7 puts 0 first");
    do_ack(); do_cmd(5, 3); tick(1);
    expect_out(1, 7, "R10 7 outranks in-service 0 after set-lowest 3");
    tag = "R9";
    do_ack(); do_cmd(3, 0); tick(1);
    expect_out(0, 0, "R9 rotate top clears 7, 0 still in service");
    do_cmd(1, 0); tick(2);

    // R3: level-following
    tag = "R3";
    do_reset(); lvl_mode = 1'b1;
    req[4] = 1'b1; tick(2);
    expect_out(1, 4, "R3 level high pending");
    req[4] = 1'b0; tick(2);
    expect_out(0, 0, "R3 level low drops request");
    lvl_mode = 1'b0;

    // R13: mark and named end on the same level in one edge
    tag = "R13";
    do_reset();
    pulse_req(3); tick(1); do_ack();
    pulse_req(1); tick(1);
    expect_out(1, 1, "R13 level 1 pending over in-service 3");
    ack = 1'b1; cmd_v = 1'b1; cmd_op = 3'd2; cmd_lvl = 3'd1;
    tick(1); ack = 1'b0; cmd_v = 1'b0;
    pulse_req(2); tick(1);
    expect_out(0, 0, "R13 mark survives same-edge clear, 2 blocked by 1");

    // R12: reserved codes and random overlap against the model
    tag = "R12";
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      if (c % 600 == 0) lvl_mode = ~lvl_mode;
      req = req ^ N'($urandom & $urandom);
      if ($urandom % 16 == 0) mask = N'($urandom & $urandom);
      ack = irq_o && ($urandom % 2 == 0);
      cmd_v = ($urandom % 6 == 0);
      cmd_op = 3'($urandom);
      cmd_lvl = W'($urandom);
      tick(1);
    end
    ack = 0; cmd_v = 0;
    tick(2);

    done = 1;
    summary();
    $finish;
  end
endmodule